// File: doc/BRIEF.md
# CCD Quadrant Line Region Tagger with Dark Clamp

This block sits on the digitized sample stream of one output of a four-output full-frame CCD. It counts accepted samples from each line strobe and lines from each frame strobe. From those counts it gives every sample a region tag: dummy, dark reference, buffer or active. The map is fixed per line. A run of dummy transport cells comes first, then light-shielded dark pixels, then light-sensitive buffer pixels, then the image pixels. The same map in a shorter form covers the 3x3 binned readout. A set number of whole dark lines opens every frame.

A window inside the dark cells of each line is averaged. Programmable skip counts trim the window at both ends, so edge pixels that may carry stray charge are left out. The mean takes the largest power-of-two number of window samples, starting from the front of the window, and is formed by a right shift. The resulting dark level is subtracted from each active pixel, and the result saturates at zero. The level holds from line to line until a new window completes, and it returns to zero at frame start.

Top module: `ccd_line_clamp`

## Requirements
- R1: After reset, pix_out_valid, pix_out, tag_out and dark_level are all zero.
- R2: In standard mode, with p the number of accepted samples since line_start, a sample is tagged dummy (00) for p < 10, dark (01) for 10 <= p < 30, buffer (10) for 30 <= p < 34 and active (11) for 34 <= p < 1546. Samples beyond the line end are tagged dummy (00).
- R3: In binned mode the map is 10 dummy cells, then 6 dark, 5 buffer and 500 active binned pixels. The tag codes are the same as in R2, and samples beyond the line end are tagged dummy.
- R4: On lines 1 to 20 after frame_start (counting line_start strobes), every sample that is not a dummy cell and lies before the line end is tagged dark (01).
- R5: Let d be a sample's index within the dark cells of its line. The window is skip_lead <= d < ndark - skip_trail, with length L. Only the first 2^k window samples are summed, where 2^k is the largest power of two not above L, and the level is that sum shifted right by k. Dummy, buffer and active samples never contribute.
- R6: dark_level changes only in the cycle after the last summed window sample. Otherwise it holds across lines, and it never updates when L is zero.
- R7: frame_start clears dark_level to zero in the next cycle and restarts the line count.
- R8: For an active sample, pix_out equals pix_in minus the dark level in force when the sample is accepted, floored at zero. For every other tag, pix_out is zero.
- R9: pix_out_valid, tag_out and pix_out appear one clock after the accepted sample, and pix_out_valid follows pix_valid.
- R10: Cycles with pix_valid low do not advance the position count. Strobes and samples are given in separate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame strobe: clears the line count and the dark level |
| line_start | input | 1 | Line strobe: restarts the position count |
| pix_valid | input | 1 | Sample strobe |
| pix_in | input | PIX_W | Digitized sample |
| binned | input | 1 | 1 selects the 3x3 binned region map |
| skip_lead | input | SKIP_W | Dark cells skipped at the window start |
| skip_trail | input | SKIP_W | Dark cells skipped at the window end |
| pix_out_valid | output | 1 | Output sample strobe |
| pix_out | output | PIX_W | Clamped active pixel, zero for other regions |
| tag_out | output | 2 | Region tag: 00 dummy, 01 dark, 10 buffer, 11 active |
| dark_level | output | PIX_W | Dark level in force |

## Verification
The hardest case to reach from the ports is the averaging window under unusual skip counts. These include a window shorter than a power of two, a window of one sample, and a window of zero length that must leave the old level in place. Each of them depends on skip_lead, skip_trail and the mode together. The bench shrinks the map through parameters and sweeps all combinations of both skip counts in both modes. It inserts idle cycles inside lines, and it drives values into the dummy and buffer cells that would visibly corrupt the mean if they were summed.

// File: rtl/ccd_clamp_pkg.sv
package ccd_clamp_pkg;
  localparam int SHIFT_W = 5;

  typedef enum logic [1:0] {
    TAG_DUMMY  = 2'b00,
    TAG_DARK   = 2'b01,
    TAG_BUFFER = 2'b10,
    TAG_ACTIVE = 2'b11
  } region_t;

  // largest k with 2^k <= v (0 for v < 2)
  function automatic int floor_log2(input int v);
    int r;
    r = 0;
    for (int i = 0; i < 31; i++)
      if (v >= (1 << i)) r = i;
    return r;
  endfunction

  // usable dark samples once both edges are trimmed
  function automatic int window_len(input int ndark, input int lead, input int trail);
    int w;
    w = ndark - lead - trail;
    return (w < 0) ? 0 : w;
  endfunction
endpackage

// File: rtl/ccd_region_tagger.sv
module ccd_region_tagger
  import ccd_clamp_pkg::*;
#(
  parameter int DUMMY      = 10,
  parameter int DARK       = 20,
  parameter int BUF        = 4,
  parameter int ACTIVE     = 1512,
  parameter int BIN_DARK   = 6,
  parameter int BIN_BUF    = 5,
  parameter int BIN_ACTIVE = 500,
  parameter int DARK_LINES = 20,
  parameter int SKIP_W     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               pix_valid,
  input  logic               binned,
  input  logic [SKIP_W-1:0]  skip_lead,
  input  logic [SKIP_W-1:0]  skip_trail,
  output region_t            tag,
  output logic               win_take,
  output logic               win_last,
  output logic [SHIFT_W-1:0] win_shift
);
  localparam int LINE_STD = DUMMY + DARK + BUF + ACTIVE;
  localparam int LINE_BIN = DUMMY + BIN_DARK + BIN_BUF + BIN_ACTIVE;
  localparam int LINE_MAX = (LINE_STD > LINE_BIN) ? LINE_STD : LINE_BIN;
  localparam int PC_LIM   = LINE_MAX + 1;
  localparam int PC_W     = $clog2(PC_LIM + 1);
  localparam int LN_LIM   = DARK_LINES + 1;
  localparam int LN_W     = $clog2(LN_LIM + 1);

  logic [PC_W-1:0] pc;
  logic [LN_W-1:0] ln;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      ln <= '0;
    end else begin
      if (frame_start)
        ln <= line_start ? LN_W'(1) : '0;
      else if (line_start && ln != LN_W'(LN_LIM))
        ln <= ln + LN_W'(1);
      if (line_start)
        pc <= '0;
      else if (pix_valid && pc != PC_W'(PC_LIM))
        pc <= pc + PC_W'(1);
    end
  end

  int   pci, nd, nb, na, line_end, wl, sh, dpos, lead, trail;
  logic dark_line, in_dark_cells;

  always_comb begin
    pci       = int'(pc);
    nd        = binned ? BIN_DARK : DARK;
    nb        = binned ? BIN_BUF : BUF;
    na        = binned ? BIN_ACTIVE : ACTIVE;
    line_end  = DUMMY + nd + nb + na;
    lead      = int'(skip_lead);
    trail     = int'(skip_trail);
    dark_line = (ln != '0) && (ln <= LN_W'(DARK_LINES));

    if (pci < DUMMY || pci >= line_end)  tag = TAG_DUMMY;
    else if (dark_line || pci < DUMMY + nd) tag = TAG_DARK;
    else if (pci < DUMMY + nd + nb)      tag = TAG_BUFFER;
    else                                 tag = TAG_ACTIVE;

    wl            = window_len(nd, lead, trail);
    sh            = floor_log2(wl);
    dpos          = pci - DUMMY;
    in_dark_cells = (pci >= DUMMY) && (pci < DUMMY + nd);
    win_take      = pix_valid && !line_start && !frame_start && in_dark_cells &&
                    (wl > 0) && (dpos >= lead) && (dpos < lead + (1 << sh));
    win_last      = win_take && (dpos == lead + (1 << sh) - 1);
    win_shift     = SHIFT_W'(sh);
  end

  // R5: only dark cells feed the window
  a_r5_window_in_dark: assert property (@(posedge clk) disable iff (!rst_n)
    win_take |-> (tag == TAG_DARK));
  // R10: idle cycles freeze the position
  a_r10_idle_holds_pos: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !line_start) |=> $stable(pc));
  // R2: each accepted sample moves the position by one
  a_r2_pos_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !line_start && pc != PC_W'(PC_LIM)) |=> (pc == $past(pc) + PC_W'(1)));
endmodule

// File: rtl/ccd_dark_avg.sv
module ccd_dark_avg
  import ccd_clamp_pkg::*;
#(
  parameter int PIX_W = 14,
  parameter int ACC_W = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               take,
  input  logic               last,
  input  logic [SHIFT_W-1:0] shift,
  input  logic [PIX_W-1:0]   sample,
  output logic [PIX_W-1:0]   level
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum;
  logic             level_load;

  assign sum        = acc + ACC_W'(sample);
  assign level_load = take && last && !frame_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      level <= '0;
    end else if (frame_start) begin
      acc   <= '0;
      level <= '0;
    end else if (line_start) begin
      acc <= '0;
    end else if (take) begin
      if (last) begin
        level <= PIX_W'(sum >> shift);
        acc   <= '0;
      end else begin
        acc <= sum;
      end
    end
  end

  // R7: frame strobe zeroes the level
  a_r7_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (level == '0));
  // R6: level moves only on a completed window
  a_r6_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !level_load) |=> $stable(level));
endmodule

// File: rtl/ccd_line_clamp.sv
module ccd_line_clamp
  import ccd_clamp_pkg::*;
#(
  parameter int PIX_W      = 14,
  parameter int DUMMY      = 10,
  parameter int DARK       = 20,
  parameter int BUF        = 4,
  parameter int ACTIVE     = 1512,
  parameter int BIN_DARK   = 6,
  parameter int BIN_BUF    = 5,
  parameter int BIN_ACTIVE = 500,
  parameter int DARK_LINES = 20,
  localparam int MAXDARK   = (DARK > BIN_DARK) ? DARK : BIN_DARK,
  localparam int SKIP_W    = $clog2(MAXDARK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              line_start,
  input  logic              pix_valid,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              binned,
  input  logic [SKIP_W-1:0] skip_lead,
  input  logic [SKIP_W-1:0] skip_trail,
  output logic              pix_out_valid,
  output logic [PIX_W-1:0]  pix_out,
  output logic [1:0]        tag_out,
  output logic [PIX_W-1:0]  dark_level
);
  localparam int ACC_W = PIX_W + $clog2(MAXDARK + 1);

  function automatic logic [PIX_W-1:0] clamp_sub(input logic [PIX_W-1:0] a,
                                                 input logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : '0;
  endfunction

  region_t            tag;
  logic               win_take, win_last;
  logic [SHIFT_W-1:0] win_shift;

  ccd_region_tagger #(
    .DUMMY(DUMMY), .DARK(DARK), .BUF(BUF), .ACTIVE(ACTIVE),
    .BIN_DARK(BIN_DARK), .BIN_BUF(BIN_BUF), .BIN_ACTIVE(BIN_ACTIVE),
    .DARK_LINES(DARK_LINES), .SKIP_W(SKIP_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .pix_valid(pix_valid), .binned(binned), .skip_lead(skip_lead),
    .skip_trail(skip_trail), .tag(tag), .win_take(win_take),
    .win_last(win_last), .win_shift(win_shift)
  );

  ccd_dark_avg #(.PIX_W(PIX_W), .ACC_W(ACC_W)) u_avg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .take(win_take), .last(win_last), .shift(win_shift), .sample(pix_in),
    .level(dark_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_out_valid <= 1'b0;
      pix_out       <= '0;
      tag_out       <= 2'b00;
    end else begin
      pix_out_valid <= pix_valid;
      if (pix_valid) begin
        tag_out <= tag;
        pix_out <= (tag == TAG_ACTIVE) ? clamp_sub(pix_in, dark_level) : '0;
      end
    end
  end

  // R8: non-image regions carry no pixel value
  a_r8_nonactive_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_out_valid && tag_out != 2'b11) |-> (pix_out == '0));
  // R8: sample at or below the dark level floors at zero
  a_r8_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && tag == TAG_ACTIVE && pix_in <= dark_level) |=> (pix_out == '0));
  // R9: output strobe follows input strobe by one cycle
  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> pix_out_valid);
endmodule

// File: tb/sim_ccd_line_clamp.sv
`timescale 1ns/1ps
module sim_ccd_line_clamp;
  localparam int PW = 10, DM = 3, DK = 8, BF = 2, AC = 6;
  localparam int BDK = 5, BBF = 1, BAC = 3, DL = 2;
  localparam int SW = $clog2(DK + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, line_start = 1'b0, pix_valid = 1'b0, binned = 1'b0;
  logic [PW-1:0] pix_in = '0;
  logic [SW-1:0] skip_lead = '0, skip_trail = '0;
  logic          pix_out_valid;
  logic [PW-1:0] pix_out, dark_level;
  logic [1:0]    tag_out;

  always #2 clk = ~clk;

  ccd_line_clamp #(.PIX_W(PW), .DUMMY(DM), .DARK(DK), .BUF(BF), .ACTIVE(AC),
    .BIN_DARK(BDK), .BIN_BUF(BBF), .BIN_ACTIVE(BAC), .DARK_LINES(DL)) u0 (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .pix_valid(pix_valid), .pix_in(pix_in), .binned(binned), .skip_lead(skip_lead),
    .skip_trail(skip_trail), .pix_out_valid(pix_out_valid), .pix_out(pix_out),
    .tag_out(tag_out), .dark_level(dark_level));

  int checks = 0, fails = 0;
  int m_pc = 0, m_ln = 0, m_level = 0, m_acc = 0;
  logic have_exp = 1'b0;
  int e_valid, e_tag, e_pix, e_level;
  string e_tag_req, e_lvl_req;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ndark(); return binned ? BDK : DK; endfunction
  function automatic int lline(); return DM + ndark() + (binned ? BBF : BF) + (binned ? BAC : AC); endfunction

  function automatic int tag_of(input int p, input int ln);
    int nd = ndark();
    if (p < DM || p >= lline()) return 0;
    if ((ln >= 1 && ln <= DL) || p < DM + nd) return 1;
    if (p < DM + nd + (binned ? BBF : BF)) return 2;
    return 3;
  endfunction

  task automatic step(input logic v, input logic fs, input logic ls, input int pix, input logic gap);
    int tg, nd, wl, n, d;
    @(negedge clk);
    if (have_exp) begin
      chk("R9 valid", int'(pix_out_valid), e_valid);
      if (e_valid != 0) begin
        chk(e_tag_req, int'(tag_out), e_tag);
        chk("R8 pixel", int'(pix_out), e_pix);
      end
      chk(e_lvl_req, int'(dark_level), e_level);
    end
    frame_start = fs; line_start = ls; pix_valid = v; pix_in = PW'(pix);
    e_valid = int'(v);
    e_lvl_req = "R6 level hold";
    if (v) begin
      tg = tag_of(m_pc, m_ln);
      e_tag = tg;
      e_tag_req = gap ? "R10 tag after idle" :
                  (m_ln >= 1 && m_ln <= DL) ? "R4 dark line tag" :
                  binned ? "R3 binned tag" : "R2 standard tag";
      e_pix = (tg == 3) ? ((pix > m_level) ? pix - m_level : 0) : 0;
      nd = ndark();
      wl = nd - int'(skip_lead) - int'(skip_trail);
      n = 1;
      while (n * 2 <= wl) n = n * 2;
      d = m_pc - DM;
      if (!fs && !ls && wl > 0 && m_pc >= DM && d < nd &&
          d >= int'(skip_lead) && d < int'(skip_lead) + n) begin
        m_acc += pix;
        if (d == int'(skip_lead) + n - 1) begin
          m_level = m_acc / n;
          m_acc = 0;
          e_lvl_req = "R5 window mean";
        end
      end
    end
    if (fs) begin
      m_level = 0; m_acc = 0; m_ln = ls ? 1 : 0;
      e_lvl_req = "R7 frame clear";
    end else if (ls && m_ln < DL + 1) m_ln++;
    if (ls) begin m_pc = 0; m_acc = 0; end
    else if (v) m_pc++;
    e_level = m_level;
    have_exp = 1'b1;
  endtask

  function automatic int value_of(input int p, input int ln, input int seed);
    int t = tag_of(p, ln);
    if (t == 1) return 40 + (p * 7 + ln * 3 + seed) % 23;
    if (t == 3) return (p * 37 + ln * 11 + seed * 5) % 90;
    return 900 + p;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", int'(pix_out_valid), 0);
    chk("R1 reset pixel", int'(pix_out), 0);
    chk("R1 reset tag", int'(tag_out), 0);
    chk("R1 reset level", int'(dark_level), 0);
    for (int mode = 0; mode < 2; mode++)
      for (int ld = 0; ld < 4; ld++)
        for (int tr = 0; tr < 4; tr++) begin
          int seed = mode * 16 + ld * 4 + tr;
          step(1'b0, 1'b0, 1'b0, 0, 1'b0);
          binned = mode[0]; skip_lead = SW'(ld); skip_trail = SW'(tr);
          step(1'b0, 1'b1, 1'b0, 0, 1'b0);
          for (int ln = 0; ln < DL + 2; ln++) begin
            int len;
            step(1'b0, 1'b0, 1'b1, 0, 1'b0);
            len = lline() + 2;
            for (int i = 0; i < len; i++) begin
              logic g = ((i + seed + ln) % 5 == 0);
              if (g) step(1'b0, 1'b0, 1'b0, 0, 1'b0);
              step(1'b1, 1'b0, 1'b0, value_of(i, m_ln, seed), g);
            end
          end
        end
    step(1'b0, 1'b0, 1'b0, 0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule